// File: doc/BRIEF.md
# Programmable Round and Window-Select Stage

This block is the last stage of a filter datapath. Each cycle it accepts a 32-bit accumulated result and a 4-bit context index. The index picks one of sixteen 32-bit rounding constants, and that constant is added to the result with wrap-around. The same index also picks one of sixteen 5-bit window codes, which choose the 16 contiguous bits of the rounded sum that are driven onto the 16-bit output.

The context index may take a different value on every cycle. Interleaved sample streams can therefore each use their own rounding and output scaling without stalling the pipeline. Both register banks are filled through a single write port, which has an enable, a 5-bit address and a 32-bit data word. Address bit 4 names the bank and bits 3:0 name the entry.

Top module: `rndwin_stage`

## Requirements
- R1: A sample (acc_in, sel_in) is captured on a rising edge E. After rising edge E+2, dout holds the window of (acc_in + round[sel_in]). The latency is three registers.
- R2: A round register is written when ld_en=1 and ld_addr[4]=0. The entry is ld_addr[3:0] and all 32 bits of ld_data are stored.
- R3: A window register is written when ld_en=1 and ld_addr[4]=1. The entry is ld_addr[3:0], only ld_data[4:0] is stored and ld_data[31:5] is ignored.
- R4: The rounding addition wraps modulo 2^32, so any carry out of bit 31 is dropped.
- R5: A window code n from 0 to 16 drives bits [n+15:n] of the rounded sum onto dout.
- R6: Window codes 17 to 31 behave as code 16, so dout carries bits [31:16].
- R7: sel_in may change on every cycle. Each sample uses the round and window entries indexed by its own sel_in.
- R8: While rst_n=0 on a rising edge, every bank entry and pipeline register is cleared, and dout reads 0 after that edge. Samples entered after reset therefore come out as acc_in[15:0].
- R9: Take a bank write and a sample capture on the same edge: that sample uses the new entry. A sample captured one edge earlier still uses the old entry.
- R10: While ld_en=0, the values on ld_addr and ld_data leave both banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_in | input | 32 | Accumulated filter result |
| sel_in | input | 4 | Context index choosing round and window entries |
| ld_en | input | 1 | Bank write enable |
| ld_addr | input | 5 | Bit 4: 0 round bank, 1 window bank; bits 3:0 entry |
| ld_data | input | 32 | Write data (window bank uses bits 4:0) |
| dout | output | 16 | Selected 16-bit slice of the rounded sum |

## Verification
A bank write and a read of the same entry by a sample in flight can fall in the same cycle. The bench sends two back-to-back samples on one context and overwrites that context's round entry on the edge that captures the second sample. The first sample must come out with the old constant and the second with the new one, and each is compared against a hand-computed value. A further pair of cycles presents a write address and data with the enable low under a live sample, and the output must show the unchanged entry.

// File: rtl/rndwin_pkg.sv
// Shared types and helpers for the round and window-select stage.
// Assumes: window codes are unsigned and compared against the largest legal shift.
package rndwin_pkg;

    // Bank chosen by the top bit of the load address.
    typedef enum logic {
        BANK_ROUND  = 1'b0,
        BANK_WINDOW = 1'b1
    } bank_sel_e;

    // Limit a window code to the largest legal shift.
    function automatic int clamp_shift(input int code, input int limit);
        return (code > limit) ? limit : code;
    endfunction

endpackage

// File: rtl/rndwin_bank.sv
// Register bank with one write port and one combinational read port.
// Assumes: at most one write per cycle; the read returns pre-edge contents,
// so a write becomes visible to readers from the following cycle.
module rndwin_bank #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [WIDTH-1:0]       rd_data,
    output logic [DEPTH*WIDTH-1:0] flat_q
);

    logic [WIDTH-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Hold one entry; clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_q[g] <= wr_data;
            end
        end

        assign flat_q[g*WIDTH +: WIDTH] = ent_q[g];
    end

    // Read the addressed entry.
    assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/rndwin_window.sv
// Bit-window selector: picks OUT_W contiguous bits of IN_W starting at the
// given code, with codes above IN_W-OUT_W clamped to the top window.
// Assumes: purely combinational; the caller registers the result.
module rndwin_window #(
    parameter int IN_W   = 32,
    parameter int OUT_W  = 16,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code,
    input  logic [IN_W-1:0]   din,
    output logic [OUT_W-1:0]  dout
);

    localparam int MAX_SHIFT = IN_W - OUT_W;

    logic [OUT_W-1:0] cand [MAX_SHIFT+1];
    int               pick;

    for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_cand
        assign cand[s] = din[s +: OUT_W];
    end

    // Choose the candidate window after clamping the code.
    always_comb begin
        pick = rndwin_pkg::clamp_shift(int'(code), MAX_SHIFT);
        dout = cand[pick];
    end

endmodule

// File: rtl/rndwin_stage.sv
// Round and window-select output stage.
// Stage 1 registers the sample and its context index. Stage 2 adds the indexed
// rounding constant (mod 2^ACC_W) and latches the indexed window code.
// Stage 3 registers the selected OUT_W-bit slice.
// Assumes: the load address top bit names the bank, the low bits the entry.
module rndwin_stage #(
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 16,
    parameter int SEL_W  = 4,
    parameter int CODE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   acc_in,
    input  logic [SEL_W-1:0]   sel_in,
    input  logic               ld_en,
    input  logic [SEL_W:0]     ld_addr,
    input  logic [ACC_W-1:0]   ld_data,
    output logic [OUT_W-1:0]   dout
);
    import rndwin_pkg::*;

    localparam int DEPTH  = 1 << SEL_W;
    localparam int ADDR_W = SEL_W + 1;

    logic [ACC_W-1:0]        acc_q;
    logic [SEL_W-1:0]        sel_q;
    logic [ACC_W-1:0]        sum_q;
    logic [CODE_W-1:0]       code_q;
    logic [OUT_W-1:0]        dout_q;
    logic [ACC_W-1:0]        rnd_rd;
    logic [CODE_W-1:0]       code_rd;
    logic [OUT_W-1:0]        win_out;
    logic [DEPTH*ACC_W-1:0]  rnd_flat;
    logic [DEPTH*CODE_W-1:0] win_flat;
    bank_sel_e               ld_bank;
    logic                    wr_round;
    logic                    wr_window;

    // Decode the load address into a bank write strobe.
    always_comb begin
        ld_bank   = bank_sel_e'(ld_addr[ADDR_W-1]);
        wr_round  = ld_en && (ld_bank == BANK_ROUND);
        wr_window = ld_en && (ld_bank == BANK_WINDOW);
    end

    rndwin_bank #(.WIDTH(ACC_W), .DEPTH(DEPTH), .IDX_W(SEL_W)) u_round_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_round),
        .wr_idx  (ld_addr[SEL_W-1:0]),
        .wr_data (ld_data),
        .rd_idx  (sel_q),
        .rd_data (rnd_rd),
        .flat_q  (rnd_flat)
    );

    rndwin_bank #(.WIDTH(CODE_W), .DEPTH(DEPTH), .IDX_W(SEL_W)) u_window_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_window),
        .wr_idx  (ld_addr[SEL_W-1:0]),
        .wr_data (ld_data[CODE_W-1:0]),
        .rd_idx  (sel_q),
        .rd_data (code_rd),
        .flat_q  (win_flat)
    );

    // Stage 1: capture the sample together with its context index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            sel_q <= '0;
        end else begin
            acc_q <= acc_in;
            sel_q <= sel_in;
        end
    end

    // Stage 2: add the rounding constant (wrapping) and latch the window code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            code_q <= '0;
        end else begin
            sum_q  <= acc_q + rnd_rd;
            code_q <= code_rd;
        end
    end

    rndwin_window #(.IN_W(ACC_W), .OUT_W(OUT_W), .CODE_W(CODE_W)) u_window (
        .code (code_q),
        .din  (sum_q),
        .dout (win_out)
    );

    // Stage 3: register the selected slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= win_out;
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/rndwin_checker.sv
// Assertion checker for rndwin_stage, attached by bind below.
// Assumes: it observes the ports plus the pipeline and bank state of the stage.
module rndwin_checker #(
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 16,
    parameter int SEL_W  = 4,
    parameter int CODE_W = 5
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [SEL_W-1:0]                sel_in,
    input logic                            ld_en,
    input logic [SEL_W:0]                  ld_addr,
    input logic [ACC_W-1:0]                ld_data,
    input logic [SEL_W-1:0]                sel_q,
    input logic [ACC_W-1:0]                sum_q,
    input logic [CODE_W-1:0]               code_q,
    input logic [OUT_W-1:0]                dout,
    input logic [(1<<SEL_W)*ACC_W-1:0]     rnd_flat,
    input logic [(1<<SEL_W)*CODE_W-1:0]    win_flat
);

    localparam int MAX_SHIFT = ACC_W - OUT_W;

    logic [SEL_W-1:0] prev_idx;
    logic [ACC_W-1:0] prev_data;

    // Remember the last load index and data for the write checks.
    always_ff @(posedge clk) begin
        prev_idx  <= ld_addr[SEL_W-1:0];
        prev_data <= ld_data;
    end

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (dout == '0));

    assert_index_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sel_q == $past(sel_in)));

    assert_round_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !ld_addr[SEL_W]) |=> (rnd_flat[prev_idx*ACC_W +: ACC_W] == prev_data));

    assert_window_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_addr[SEL_W]) |=> (win_flat[prev_idx*CODE_W +: CODE_W] == prev_data[CODE_W-1:0]));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> ($stable(rnd_flat) && $stable(win_flat)));

    assert_low_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0) |=> (dout == $past(sum_q[OUT_W-1:0])));

    assert_clamp_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(code_q) >= MAX_SHIFT) |=> (dout == $past(sum_q[ACC_W-1:MAX_SHIFT])));

endmodule

bind rndwin_stage rndwin_checker #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .SEL_W(SEL_W), .CODE_W(CODE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_in   (sel_in),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .sel_q    (sel_q),
    .sum_q    (sum_q),
    .code_q   (code_q),
    .dout     (dout),
    .rnd_flat (rnd_flat),
    .win_flat (win_flat)
);

// File: tb/rndwin_stage_bench.sv
// Bench for rndwin_stage: a vector table streamed one sample per cycle,
// then directed tests for reset, write/read collision and ignored loads.
module rndwin_stage_bench;

    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] acc_in = '0;
    logic [3:0]  sel_in = '0;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [15:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Stimulus table: accumulator, context, expected output.
    localparam logic [31:0] T_ACC [NV] = '{
        32'h1234_5678, 32'h1234_8000, 32'h1234_7FFF, 32'h0000_ABCD,
        32'hF000_0003, 32'h0000_0000, 32'h0001_0000, 32'hABCD_1234,
        32'h9000_1200, 32'hFFFF_FFFF, 32'h8765_4321};
    localparam logic [3:0] T_SEL [NV] = '{
        4'd0, 4'd1, 4'd1, 4'd2, 4'd3, 4'd15, 4'd15, 4'd14, 4'd7, 4'd0, 4'd2};
    localparam logic [15:0] T_EXP [NV] = '{
        16'h5678, 16'h1235, 16'h1234, 16'h0ABD, 16'h0002, 16'hFFFF,
        16'h0000, 16'hABCD, 16'h0012, 16'hFFFF, 16'h5432};

    rndwin_stage u_rndwin_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_in  (acc_in),
        .sel_in  (sel_in),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .dout    (dout)
    );

    always #10 clk = ~clk;

    function automatic string tag_of(int i);
        case (i)
            0, 9:    return "R5";
            1, 2:    return "R1";
            3, 4:    return "R2/R3";
            5, 7:    return "R6";
            6, 8:    return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic bank, logic [3:0] idx, logic [31:0] data);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = {bank, idx};
        ld_data = data;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    initial begin
        // R8: reset clears the output.
        repeat (4) @(negedge clk);
        chk("R8", dout, 16'h0000);
        rst_n  = 1'b1;
        acc_in = 32'h1234_ABCD; sel_in = 4'd5;
        @(negedge clk);
        chk("R8", dout, 16'h0000);
        acc_in = 32'h0F0F_F0F0; sel_in = 4'd9;
        @(negedge clk);
        acc_in = '0; sel_in = '0;
        @(negedge clk);
        chk("R8", dout, 16'hABCD);
        @(negedge clk);
        chk("R8", dout, 16'hF0F0);

        // Bank set-up (R2 round writes, R3 window writes).
        wr(1'b0, 4'd1,  32'h0000_8000); wr(1'b1, 4'd1,  32'd16);
        wr(1'b0, 4'd2,  32'h0000_0008); wr(1'b1, 4'd2,  32'd4);
        wr(1'b0, 4'd3,  32'h0000_0001); wr(1'b1, 4'd3,  32'hFFFF_FFE1);
        wr(1'b0, 4'd7,  32'h8000_0000); wr(1'b1, 4'd7,  32'd8);
        wr(1'b1, 4'd14, 32'd17);
        wr(1'b0, 4'd15, 32'hFFFF_FFFF); wr(1'b1, 4'd15, 32'd31);

        // Table walk: one sample per cycle, checked three edges later (R1, R7).
        for (int j = 0; j < NV + 3; j++) begin
            @(negedge clk);
            if (j >= 3) chk(tag_of(j - 3), dout, T_EXP[j-3]);
            if (j < NV) begin
                acc_in = T_ACC[j]; sel_in = T_SEL[j];
            end else begin
                acc_in = '0; sel_in = '0;
            end
        end

        // R9: write to round entry 3 on the edge capturing the second sample.
        acc_in = 32'h0000_0100; sel_in = 4'd3;
        @(negedge clk);
        acc_in = 32'h0000_0100; sel_in = 4'd3;
        ld_en = 1'b1; ld_addr = 5'b0_0011; ld_data = 32'h0000_0100;
        @(negedge clk);
        ld_en = 1'b0; acc_in = '0; sel_in = '0;
        @(negedge clk);
        chk("R9 old entry", dout, 16'h0080);
        @(negedge clk);
        chk("R9 new entry", dout, 16'h0100);

        // R10: address and data with ld_en low must not touch either bank.
        ld_en = 1'b0; ld_addr = 5'b0_0011; ld_data = 32'hDEAD_BEEF;
        acc_in = 32'h0000_0100; sel_in = 4'd3;
        @(negedge clk);
        ld_addr = 5'b1_0011; ld_data = 32'h0000_0000;
        acc_in = 32'h0000_0100; sel_in = 4'd3;
        @(negedge clk);
        ld_addr = '0; ld_data = '0; acc_in = '0; sel_in = '0;
        @(negedge clk);
        chk("R10", dout, 16'h0100);
        @(negedge clk);
        chk("R10", dout, 16'h0100);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: dout=%h expected=completion", dout);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule